// File: doc/BRIEF.md
# E1 Transmit Framer with In-Line CRC-4 Patching

This block sits on the transmit side of a 2.048 Mbit/s E1 port. It takes a serial stream of 256-bit frames: 32 timeslots of 8 bits, sent most significant bit first, one bit per clock. It produces the stream that goes to the line coder. A frame sync input marks the first bit of a frame. A multiframe sync input marks the first bit of frame 0 of a 16-frame CRC-4 multiframe. The block keeps its own bit and frame counters locked to these two pulses.

A configuration register selects one of three behaviours:

- **Termination mode:** the block builds timeslot 0 itself. This covers the alignment word, the multiframe pattern, the CRC-4 bits, the remote alarm bit and the national bits. It can also put a local signalling bit into timeslot 16.
- **Transparent mode:** the block lets the whole frame through but overwrites selected national bits. It does not compute a fresh CRC-4. Instead it adds the CRC-4 of the bit changes it made onto the incoming check bits. A span error upstream is therefore still seen downstream.
- **Unframed mode:** the data is never touched.

A software reset input and the hardware reset both return the configuration to unframed.

Top module: `e1tx_framer`

## Requirements
- R1: While `rst` is high, `tx_out` is 0. After reset the configuration is all zero, so the block starts in unframed mode.
- R2: Unframed mode (`cfg_wdata[1:0]` = 00 or 11) gives `tx_out` equal to `tx_in` one clock later for every bit. This holds even when the timeslot 16 enable (`cfg_wdata[3]`) is set.
- R3: In termination mode (`cfg_wdata[1:0]` = 01), in even frames, timeslot 0 bits 2 to 8 (bit 1 is sent first) are 0,0,1,1,0,1,1.
- R4: In termination mode, in odd frames, timeslot 0 bit 2 is 1 and bit 3 is the alarm bit `cfg_wdata[4]`. Bits 4 to 8 are `dl_bit` as sampled with each of those bits.
- R5: In termination mode with CRC enabled (`cfg_wdata[2]`), bit 1 of timeslot 0 works as follows.
  - Even frames carry C1..C4. These are the x^4+x+1 remainder (MSB first) of the previous 8-frame half of the multiframe, computed over the output with the C positions taken as 0.
  - Odd frames 1,3,5,7,9,11,13,15 carry 0,0,1,0,1,1,1,1.
  - With CRC disabled, bit 1 is always 1.
- R6: In termination mode, timeslot 16 carries `sig_bit` when `cfg_wdata[3]` is set. All timeslots other than 0 (and other than 16 when that enable is set) pass `tx_in` unchanged.
- R7: In transparent mode (`cfg_wdata[1:0]` = 10), every bit passes unchanged except national bit SaN of odd frames (timeslot 0 bit N, N=4..8). That bit is replaced by `dl_bit` when mask bit `cfg_wdata[N+1]` is set.
- R8: In transparent mode with CRC enabled, each outgoing C bit is the incoming C bit XOR the CRC-4 of the change pattern (output XOR input) over the previous half-multiframe. An input with a valid CRC-4 therefore yields an output with a valid CRC-4. With CRC disabled, the C bits pass unchanged.
- R9: Frame sync restarts the bit count at the current bit. Multiframe sync also restarts the frame count, at any point in the stream.
- R10: A `sw_rst` pulse returns the configuration to unframed from the next bit on. Alignment is kept. A `sw_rst` takes priority over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset of the configuration register |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 10 | [1:0] mode, [2] CRC enable, [3] timeslot 16 enable, [4] alarm bit, [9:5] Sa4..Sa8 replace mask |
| frame_sync | input | 1 | High with the first bit of a frame |
| mframe_sync | input | 1 | High with the first bit of multiframe frame 0 |
| tx_in | input | 1 | Serial transmit data in |
| dl_bit | input | 1 | Replacement national (data link) bit source |
| sig_bit | input | 1 | Local timeslot 16 signalling bit source |
| tx_out | output | 1 | Registered serial transmit data out |

## Verification
The hardest situation to reach is the transparent check-bit patch. It can only be judged against an incoming stream whose own CRC-4 is correct. The mode must also stay stable over a whole half-multiframe before the patched bits appear.

The bench therefore generates its input stream with a running CRC-4 of its own, inserting valid C bits. On the output side, a separate receiver recomputes CRC-4 over what the block emits. It compares the result with the C bits of the next half-multiframe, but only when the previous half was spent entirely in one CRC-enabled mode. Realignment, mode changes and resets each invalidate that receiver until it has seen a clean half-multiframe again.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

  typedef enum logic [1:0] {
    MODE_UNFRAMED     = 2'b00,
    MODE_TERM         = 2'b01,
    MODE_TRANSP       = 2'b10,
    MODE_UNFRAMED_ALT = 2'b11
  } tx_mode_e;

  typedef struct packed {
    logic [4:0] sa_mask;
    logic       rai;
    logic       ts16_en;
    logic       crc_en;
    tx_mode_e   mode;
  } tx_cfg_t;

  localparam int CFG_W = $bits(tx_cfg_t);

  // alignment word in bits [6:0], indexed by (7 - bit offset)
  localparam logic [7:0] FAS_WORD = 8'h1B;
  // multiframe bits of odd frames, indexed by frame number / 2
  localparam logic [7:0] MF_PATTERN = 8'hF4;

  function automatic logic [3:0] crc4_step(input logic [3:0] r, input logic b);
    logic fb;
    fb = r[3] ^ b;
    return {r[2], r[1], r[0] ^ fb, fb};
  endfunction

endpackage

// File: rtl/e1tx_cfg_reg.sv
module e1tx_cfg_reg
  import e1tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sw_rst,
  input  logic    wr,
  input  tx_cfg_t wdata,
  output tx_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst || sw_rst) cfg_q <= '0;
    else if (wr)       cfg_q <= wdata;
  end

  assert_swrst_clear_R10: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (cfg_q == '0));

endmodule

// File: rtl/e1tx_position.sv
module e1tx_position #(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sync,
  input  logic             mframe_sync,
  output logic [BIT_W-1:0] cur_bit,
  output logic [FRM_W-1:0] cur_frm
);

  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;
  logic             frame_end;

  assign cur_bit   = (frame_sync || mframe_sync) ? '0 : bit_q;
  assign cur_frm   = mframe_sync ? '0 : frm_q;
  assign frame_end = (cur_bit == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      frm_q <= '0;
    end else begin
      bit_q <= frame_end ? '0 : cur_bit + 1'b1;
      if (frame_end)
        frm_q <= (cur_frm == FRM_W'(MF_FRAMES - 1)) ? '0 : cur_frm + 1'b1;
      else
        frm_q <= cur_frm;
    end
  end

  assert_fp_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_sync || mframe_sync) |=> (bit_q == BIT_W'(1)));

  assert_mfp_restart_R9: assert property (@(posedge clk) disable iff (rst)
    mframe_sync |=> (frm_q == '0));

endmodule

// File: rtl/e1tx_crc4_acc.sv
module e1tx_crc4_acc
  import e1tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       feed,
  input  logic       last,
  output logic [3:0] hold
);

  logic [3:0] acc;
  logic [3:0] acc_next;

  assign acc_next = crc4_step(acc, feed);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      hold <= '0;
    end else if (last) begin
      acc  <= '0;
      hold <= acc_next;
    end else begin
      acc  <= acc_next;
    end
  end

  assert_acc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    last |=> (acc == '0));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(hold));

endmodule

// File: rtl/e1tx_framer.sv
module e1tx_framer
  import e1tx_pkg::*;
#(
  parameter int TS_BITS    = 8,
  parameter int NUM_TS     = 32,
  parameter int MF_FRAMES  = 16,
  parameter int SMF_FRAMES = 8,
  parameter int SIG_TS     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             frame_sync,
  input  logic             mframe_sync,
  input  logic             tx_in,
  input  logic             dl_bit,
  input  logic             sig_bit,
  output logic             tx_out
);

  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int FRM_W      = $clog2(MF_FRAMES);
  localparam int TSB_W      = $clog2(TS_BITS);
  localparam int SMF_W      = $clog2(SMF_FRAMES);
  localparam int TS_W       = BIT_W - TSB_W;

  tx_cfg_t          cfg;
  logic [BIT_W-1:0] cur_bit;
  logic [FRM_W-1:0] cur_frm;
  logic [3:0]       hold;

  e1tx_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .sw_rst(sw_rst),
    .wr    (cfg_wr),
    .wdata (tx_cfg_t'(cfg_wdata)),
    .cfg_q (cfg)
  );

  e1tx_position #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_pos (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .mframe_sync(mframe_sync),
    .cur_bit    (cur_bit),
    .cur_frm    (cur_frm)
  );

  // position decode
  logic [TSB_W-1:0]   tsbit;
  logic [TS_W-1:0]    ts_idx;
  logic [SMF_W-2:0]   c_idx;
  logic [FRM_W-2:0]   mf_pair;
  logic [TSB_W-1:0]   sa_sel;
  logic [TS_BITS-1:0] sa_mask_ext;
  logic               in_ts0, in_sig, is_odd, is_c, is_sa, smf_last;
  logic               c_val;

  assign tsbit       = cur_bit[TSB_W-1:0];
  assign ts_idx      = cur_bit[BIT_W-1:TSB_W];
  assign in_ts0      = (ts_idx == '0);
  assign in_sig      = (ts_idx == TS_W'(SIG_TS));
  assign is_odd      = cur_frm[0];
  assign c_idx       = cur_frm[SMF_W-1:1];
  assign mf_pair     = cur_frm[FRM_W-1:1];
  assign is_c        = in_ts0 && (tsbit == '0) && !is_odd;
  assign is_sa       = in_ts0 && is_odd && (tsbit >= TSB_W'(3));
  assign sa_sel      = tsbit - TSB_W'(3);
  assign sa_mask_ext = TS_BITS'(cfg.sa_mask);
  assign c_val       = hold[~c_idx];
  assign smf_last    = (cur_bit == BIT_W'(FRAME_BITS - 1)) &&
                       (cur_frm[SMF_W-1:0] == {SMF_W{1'b1}});

  logic out_next;
  logic feed;

  always_comb begin
    out_next = tx_in;
    unique case (cfg.mode)
      MODE_TERM: begin
        if (in_ts0) begin
          if (tsbit == '0)
            out_next = !cfg.crc_en ? 1'b1 : (is_odd ? MF_PATTERN[mf_pair] : c_val);
          else if (!is_odd)
            out_next = FAS_WORD[TSB_W'(TS_BITS - 1) - tsbit];
          else if (tsbit == TSB_W'(1))
            out_next = 1'b1;
          else if (tsbit == TSB_W'(2))
            out_next = cfg.rai;
          else
            out_next = dl_bit;
        end else if (in_sig && cfg.ts16_en) begin
          out_next = sig_bit;
        end
      end
      MODE_TRANSP: begin
        if (is_sa && sa_mask_ext[sa_sel])
          out_next = dl_bit;
        else if (is_c && cfg.crc_en)
          out_next = tx_in ^ c_val;
      end
      default: out_next = tx_in;
    endcase
  end

  // termination: remainder of the outgoing data; transparent: remainder of the change pattern
  assign feed = is_c ? 1'b0 : ((cfg.mode == MODE_TERM) ? out_next : (out_next ^ tx_in));

  e1tx_crc4_acc u_crc (
    .clk (clk),
    .rst (rst),
    .feed(feed),
    .last(smf_last),
    .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_out <= 1'b0;
    else     tx_out <= out_next;
  end

  logic unframed;
  assign unframed = (cfg.mode == MODE_UNFRAMED) || (cfg.mode == MODE_UNFRAMED_ALT);

  assert_unframed_pass_R2: assert property (@(posedge clk) disable iff (rst)
    unframed |=> (tx_out == $past(tx_in)));

  assert_transp_payload_R7: assert property (@(posedge clk) disable iff (rst)
    ((cfg.mode == MODE_TRANSP) && !in_ts0) |=> (tx_out == $past(tx_in)));

  assert_odd_bit2_R4: assert property (@(posedge clk) disable iff (rst)
    ((cfg.mode == MODE_TERM) && in_ts0 && is_odd && (tsbit == TSB_W'(1))) |=> tx_out);

  assert_ts16_sig_R6: assert property (@(posedge clk) disable iff (rst)
    ((cfg.mode == MODE_TERM) && in_sig && cfg.ts16_en) |=> (tx_out == $past(sig_bit)));

endmodule

// File: tb/test_e1tx_framer.sv
`timescale 1ns/1ps
module test_e1tx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_rst = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic       frame_sync = 1'b0;
  logic       mframe_sync = 1'b0;
  logic       tx_in = 1'b0;
  logic       dl_bit = 1'b0;
  logic       sig_bit = 1'b0;
  logic       tx_out;

  always #4 clk = ~clk;

  e1tx_framer i_e1tx_framer (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .frame_sync(frame_sync), .mframe_sync(mframe_sync), .tx_in(tx_in),
    .dl_bit(dl_bit), .sig_bit(sig_bit), .tx_out(tx_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int bpos = 0, fpos = 0;
  logic [9:0] mcfg = '0;
  logic [3:0] macc = '0, mhold = '0;
  logic [3:0] gacc = '0, ghold = '0;
  logic [3:0] dacc = '0, dhold = '0;
  bit smf_clean = 0, ds_ok = 0, smf_first = 1;
  int smf_mode = 0, ds_mode = 0;
  int tag_left = 0;
  string tag_name = "";

  bit    have_exp = 0;
  logic  exp_out;
  string exp_req;
  int    exp_b, exp_f, exp_m;
  bit    exp_crcm;

  function automatic logic [3:0] crc_nx(input logic [3:0] r, input logic b);
    logic f;
    f = r[3] ^ b;
    return {r[2], r[1], r[0] ^ f, f};
  endfunction

  function automatic logic fas_val(input int k);
    return (k == 3 || k == 4 || k == 6 || k == 7);
  endfunction

  function automatic logic mf_val(input int k);
    return (k == 2 || k >= 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic act, input logic ex);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at bit %0d frame %0d: actual=%0b expected=%0b", req, exp_b, exp_f, act, ex);
    end
  endtask

  // expected output from the requirements, plus the check-bit register it implies
  task automatic model_bit(input logic d, input logic s, input logic g,
                           output logic o, output string r);
    int m, tb, ts, ci;
    bit odd, isc;
    logic fd;
    m = int'(mcfg[1:0]); tb = bpos % 8; ts = bpos / 8;
    odd = fpos[0]; ci = (fpos % 8) / 2;
    isc = (ts == 0) && (tb == 0) && !odd;
    o = d; r = "R2";
    if (m == 1) begin
      r = "R6";
      if (ts == 0) begin
        if (tb == 0) begin
          r = "R5";
          o = !mcfg[2] ? 1'b1 : (odd ? mf_val(fpos / 2) : mhold[3-ci]);
        end else if (!odd) begin
          r = "R3"; o = fas_val(tb);
        end else begin
          r = "R4"; o = (tb == 1) ? 1'b1 : (tb == 2) ? mcfg[4] : s;
        end
      end else if (ts == 16 && mcfg[3]) begin
        o = g;
      end
    end else if (m == 2) begin
      r = "R7";
      if (ts == 0 && odd && tb >= 3 && mcfg[5 + tb - 3]) o = s;
      else if (isc) begin
        r = "R8";
        if (mcfg[2]) o = d ^ mhold[3-ci];
      end
    end
    fd = isc ? 1'b0 : ((m == 1) ? o : (o ^ d));
    macc = crc_nx(macc, fd);
    if (bpos == 255 && fpos % 8 == 7) begin mhold = macc; macc = '0; end
  endtask

  // receiver-side CRC-4 check of the emitted stream
  task automatic downstream(input logic o);
    bit isc;
    int ci;
    isc = (exp_b == 0) && (exp_f % 2 == 0);
    ci  = (exp_f % 8) / 2;
    if (isc && ds_ok && exp_crcm && exp_m == ds_mode)
      chk(o === dhold[3-ci], (ds_mode == 1) ? "R5 rx-crc" : "R8 rx-crc", o, dhold[3-ci]);
    if (!exp_crcm) smf_clean = 0;
    if (smf_first) begin smf_mode = exp_m; smf_first = 0; end
    else if (exp_m != smf_mode) smf_clean = 0;
    dacc = crc_nx(dacc, isc ? 1'b0 : o);
    if (exp_b == 255 && exp_f % 8 == 7) begin
      dhold = dacc; dacc = '0;
      ds_ok = smf_clean; ds_mode = smf_mode;
      smf_clean = 1; smf_first = 1;
    end
  endtask

  task automatic step(input logic wr, input logic [9:0] wd, input logic srst, input logic realign);
    logic d, s, g, o;
    bit isc;
    int ci;
    string r;
    @(negedge clk);
    if (have_exp) begin
      chk(tx_out === exp_out, exp_req, tx_out, exp_out);
      downstream(tx_out);
    end
    if (realign) begin
      bpos = 0; fpos = 0; gacc = '0;
      smf_clean = 0; ds_ok = 0; smf_first = 1;
      tag_left = 256; tag_name = "R9";
    end
    isc = (bpos == 0) && (fpos % 2 == 0);
    ci  = (fpos % 8) / 2;
    s = 1'($urandom % 2);
    g = 1'($urandom % 2);
    d = isc ? ghold[3-ci] : 1'($urandom % 2);
    gacc = crc_nx(gacc, isc ? 1'b0 : d);
    if (bpos == 255 && fpos % 8 == 7) begin ghold = gacc; gacc = '0; end
    model_bit(d, s, g, o, r);
    if (tag_left > 0) begin r = tag_name; tag_left--; end
    rst = 1'b0; frame_sync = (bpos == 0); mframe_sync = (bpos == 0 && fpos == 0);
    tx_in = d; dl_bit = s; sig_bit = g;
    cfg_wr = wr; cfg_wdata = wd; sw_rst = srst;
    have_exp = 1; exp_out = o; exp_req = r; exp_b = bpos; exp_f = fpos;
    exp_m = int'(mcfg[1:0]);
    exp_crcm = mcfg[2] && (mcfg[1:0] == 2'b01 || mcfg[1:0] == 2'b10);
    if (srst) begin mcfg = '0; tag_left = 256; tag_name = "R10"; end
    else if (wr) mcfg = wd;
    bpos++;
    if (bpos == 256) begin bpos = 0; fpos = (fpos + 1) % 16; end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0; sw_rst = 1'b0;
    have_exp = 0;
    repeat (3) @(negedge clk);
    chk(tx_out === 1'b0, "R1 reset", tx_out, 1'b0);
    bpos = 0; fpos = 0; mcfg = '0; macc = '0; mhold = '0; gacc = '0;
    smf_clean = 0; ds_ok = 0; smf_first = 1; dacc = '0;
    tag_left = 256; tag_name = "R1";
  endtask

  localparam int MF = 4096;

  initial begin
    void'($urandom(32'h5eed_e101));
    do_reset();
    step(1'b1, 10'h008, 1'b0, 1'b0);       // R2: unframed with ts16 enable set
    run(2 * MF);
    step(1'b1, 10'h01D, 1'b0, 1'b0);       // termination, CRC, ts16, alarm
    run(3 * MF);
    step(1'b1, 10'h001, 1'b0, 1'b0);       // termination, CRC off
    run(MF);
    step(1'b1, 10'h3E6, 1'b0, 1'b0);       // transparent, CRC, all Sa
    run(3 * MF);
    step(1'b1, 10'h2A6, 1'b0, 1'b0);       // transparent, Sa4/Sa6/Sa8
    run(2 * MF);
    step(1'b1, 10'h3E2, 1'b0, 1'b0);       // transparent, CRC off
    run(MF);
    step(1'b1, 10'h3E6, 1'b0, 1'b0);
    run(2 * MF + 1000);
    step(1'b0, '0, 1'b0, 1'b1);            // R9: realign mid-frame
    run(3 * MF);
    step(1'b1, 10'h01D, 1'b0, 1'b0);
    run(MF + 777);
    step(1'b0, '0, 1'b0, 1'b1);            // R9 in termination
    run(2 * MF);
    step(1'b1, 10'h01D, 1'b1, 1'b0);       // R10: sw reset beats write
    run(MF);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 10'($urandom), 1'b0, 1'b0);
      run(MF);
    end
    run(500);
    do_reset();                            // hardware reset mid-run
    step(1'b0, '0, 1'b0, 1'b0);
    run(MF);
    @(negedge clk);
    chk(tx_out === exp_out, exp_req, tx_out, exp_out);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule